// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer Counter

A counter of parameterized width that advances once per prescaled tick. The tick comes from a free-running divider, so the count steps once every `prescale + 1` clock cycles while the block is enabled. A 3-bit mode word sets how the counter moves. It can count up to a programmed limit, count down from that limit, or sweep up and back down in a triangle. Each of these runs either periodically or as a single pass that parks at its end.

The block watches the count for two programmable compare values and for the end of each pass. It reports each of these events as a one-cycle pulse on the tick that takes the count away from the matching value. A direction output tells a downstream waveform stage which slope the counter is on. Software or a sequencer starts or restarts a pass by pulsing `restart` high and then low. The load happens on the falling edge of that pulse.

Top module: `prescaled_timer`

## Requirements
- R1: While `enable` is 1, the count steps exactly once every `prescale + 1` clock cycles, counted from the clock edge that performed the last restart load.
- R2: With mode bits [1:0] = 2'b10 (up), the count runs 0, 1, …, `reload`. In periodic mode it then returns to 0.
- R3: With mode bits [1:0] = 2'b01 (down), the count runs `reload`, `reload`−1, …, 0. In periodic mode it then returns to `reload`.
- R4: With mode bits [1:0] = 2'b11 (up/down, `reload` ≥ 1), the count runs 0 up to `reload`, back down to 0, then up again. `counting_down` is 1 from the step that leaves `reload` until the step that leaves 0. In up mode it is always 0 and in down mode always 1.
- R5: `timeout` pulses for one cycle on the tick that steps away from `reload` (up, and the peak of up/down) or away from 0 (down).
- R6: `match_x` and `match_y` pulse for one cycle on a tick during which `count` equals `cmp_x` or `cmp_y` respectively. They are 0 at all other times.
- R7: With mode bit 2 = 0 (one-shot), the count holds its end value after the timeout step. No further `timeout`, `match_x` or `match_y` pulses occur until a restart.
- R8: A falling edge on `restart` loads the start value on that clock edge (`reload` in down mode, 0 otherwise), clears the prescaler and restarts the pass, whatever the previous state.
- R9: While `enable` is 0, the count is frozen and no flag pulses. After re-enabling, the first step comes `prescale + 1` edges later.
- R10: With mode bits [1:0] = 2'b00, the count is held and no flag pulses, even when a compare value equals the count.
- R11: After reset, `count` is 0 and all flags and `counting_down` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the prescaler and counter |
| restart | input | 1 | Restart strobe; acts on its falling edge |
| reload | input | CNT_W | End value when counting up, start value when counting down |
| cmp_x | input | CNT_W | First compare value |
| cmp_y | input | CNT_W | Second compare value |
| prescale | input | PRE_W | Tick divider; tick period is prescale + 1 cycles |
| mode_cfg | input | 3 | [1:0] direction (10 up, 01 down, 11 up/down, 00 hold); [2] 1 periodic, 0 one-shot |
| count | output | CNT_W | Current count |
| match_x | output | 1 | One-cycle pulse on a tick with count equal to cmp_x |
| match_y | output | 1 | One-cycle pulse on a tick with count equal to cmp_y |
| timeout | output | 1 | One-cycle pulse on the step leaving the end of a pass |
| counting_down | output | 1 | Current slope of the counter |

## Verification
The bench sweeps every direction, both run modes, several prescale values and small reload values, including a reload of 0. It predicts count, flags and slope with closed-form arithmetic on the tick index. A counter whose turnaround is off by one would show the peak or the valley twice, and the triangle would drift. A one-shot that keeps running after its timeout would repeat the sequence and fire extra flags. Separate checks cover a compare value parked on a frozen count, both with `enable` low and in hold mode, where a design that fails to gate its flags would pulse. A further check covers the re-enable delay, which a prescaler that is not cleared would cut short.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_DOWN = 2'b01,
    DIR_UP   = 2'b10,
    DIR_BOTH = 2'b11
  } dir_e;

  typedef struct packed {
    logic periodic;
    dir_e dir;
  } mode_t;

  localparam int N_CMP = 2;

endpackage

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;

  function automatic logic reached(input logic [PRE_W-1:0] c, input logic [PRE_W-1:0] lim);
    return c >= lim;
  endfunction

  assign tick = enable && reached(pre_q, prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pre_q <= '0;
    else if (!enable || clear || tick)   pre_q <= '0;
    else                                 pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  mode_t            mode,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             going_down,
  output logic             step,
  output logic             end_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;
  logic             done_q;
  logic             at_end;

  function automatic logic is_terminal(input dir_e d, input logic dn,
                                       input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] r);
    case (d)
      DIR_UP:   return c == r;
      DIR_DOWN: return c == '0;
      DIR_BOTH: return !dn && (c == r);
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] next_val(input dir_e d, input logic dn,
                                                input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] r);
    case (d)
      DIR_UP:   return (c == r)  ? '0 : c + 1'b1;
      DIR_DOWN: return (c == '0) ? r  : c - 1'b1;
      DIR_BOTH: begin
        if (!dn) return (c == r)  ? ((r == '0) ? '0 : r - 1'b1) : c + 1'b1;
        else     return (c == '0) ? ((r == '0) ? '0 : CNT_W'(1)) : c - 1'b1;
      end
      default:  return c;
    endcase
  endfunction

  function automatic logic next_dir(input dir_e d, input logic dn,
                                    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] r);
    if (d != DIR_BOTH)          return dn;
    if (!dn && (c == r))        return 1'b1;
    if (dn && (c == '0))        return 1'b0;
    return dn;
  endfunction

  function automatic logic [CNT_W-1:0] start_val(input dir_e d, input logic [CNT_W-1:0] r);
    return (d == DIR_DOWN) ? r : '0;
  endfunction

  assign step    = tick && !load && !done_q && (mode.dir != DIR_HOLD);
  assign at_end  = is_terminal(mode.dir, down_q, cnt_q, reload);
  assign end_evt = step && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= start_val(mode.dir, reload);
      down_q <= 1'b0;
      done_q <= 1'b0;
    end else if (step) begin
      if (at_end && !mode.periodic) begin
        done_q <= 1'b1;
      end else begin
        cnt_q  <= next_val(mode.dir, down_q, cnt_q, reload);
        down_q <= next_dir(mode.dir, down_q, cnt_q, reload);
      end
    end
  end

  assign count      = cnt_q;
  assign going_down = (mode.dir == DIR_DOWN) || ((mode.dir == DIR_BOTH) && down_q);

endmodule

// File: rtl/ptmr_match_unit.sv
module ptmr_match_unit #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 2
) (
  input  logic                       step,
  input  logic [CNT_W-1:0]           count,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp,
  output logic [N_CH-1:0]            hit
);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign hit[g] = step && (count == cmp[g]);
  end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_x,
  input  logic [CNT_W-1:0] cmp_y,
  input  logic [PRE_W-1:0] prescale,
  input  logic [2:0]       mode_cfg,
  output logic [CNT_W-1:0] count,
  output logic             match_x,
  output logic             match_y,
  output logic             timeout,
  output logic             counting_down
);

  logic                        restart_q;
  logic                        restart_ld;
  logic                        tick;
  logic                        step;
  mode_t                       mode;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_all;
  logic [N_CMP-1:0]            hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= restart;
  end

  assign restart_ld = restart_q && !restart;
  assign mode       = mode_t'(mode_cfg);
  assign cmp_all    = {cmp_y, cmp_x};

  ptmr_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .clear    (restart_ld),
    .prescale (prescale),
    .tick     (tick)
  );

  ptmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (restart_ld),
    .mode       (mode),
    .reload     (reload),
    .count      (count),
    .going_down (counting_down),
    .step       (step),
    .end_evt    (timeout)
  );

  ptmr_match_unit #(.CNT_W(CNT_W), .N_CH(N_CMP)) u_match (
    .step  (step),
    .count (count),
    .cmp   (cmp_all),
    .hit   (hits)
  );

  assign match_x = hits[0];
  assign match_y = hits[1];

endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             restart_ld,
  input logic             tick,
  input logic             step,
  input logic [2:0]       mode_cfg,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cmp_x,
  input logic [CNT_W-1:0] cmp_y,
  input logic [PRE_W-1:0] prescale,
  input logic             match_x,
  input logic             match_y,
  input logic             timeout,
  input logic             counting_down
);

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || prescale == '0));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_cfg[1:0] == 2'b10 && count != reload) |=> count == $past(count) + 1'b1);

  // R4
  valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_cfg == 3'b111 && counting_down && count == '0 && reload != '0)
      |=> (count == CNT_W'(1) && !counting_down));

  // R5
  timeout_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> tick);

  // R6
  match_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_x |-> (tick && count == cmp_x));

  // R6
  match_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_y |-> (tick && count == cmp_y));

  // R7
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !mode_cfg[2]) |=> (count == $past(count) && !timeout));

  // R8
  load_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_ld && mode_cfg[1:0] == 2'b01) |=> count == $past(reload));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart_ld) |=> $stable(count));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!timeout && !match_x && !match_y));

endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .restart_ld    (restart_ld),
  .tick          (tick),
  .step          (step),
  .mode_cfg      (mode_cfg),
  .count         (count),
  .reload        (reload),
  .cmp_x         (cmp_x),
  .cmp_y         (cmp_y),
  .prescale      (prescale),
  .match_x       (match_x),
  .match_y       (match_y),
  .timeout       (timeout),
  .counting_down (counting_down)
);

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;

  localparam int CNT_W = 32;
  localparam int PRE_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             restart = 1'b0;
  logic [CNT_W-1:0] reload = '0;
  logic [CNT_W-1:0] cmp_x = '0;
  logic [CNT_W-1:0] cmp_y = '0;
  logic [PRE_W-1:0] prescale = '0;
  logic [2:0]       mode_cfg = 3'b000;
  logic [CNT_W-1:0] count;
  logic             match_x, match_y, timeout, counting_down;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prescaled_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut (
    .clk (clk), .rst_n (rst_n), .enable (enable), .restart (restart),
    .reload (reload), .cmp_x (cmp_x), .cmp_y (cmp_y), .prescale (prescale),
    .mode_cfg (mode_cfg), .count (count), .match_x (match_x), .match_y (match_y),
    .timeout (timeout), .counting_down (counting_down)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic pulse_restart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  // dirc: 2 up, 1 down, 3 up/down; per: 1 periodic, 0 one-shot
  task automatic run_case(input int dirc, input int per, input int p, input int n, input int kmax);
    int cx, cy;
    cx = 1;
    cy = n / 2;
    @(negedge clk);
    mode_cfg = 3'(per * 4 + dirc);
    prescale = PRE_W'(p);
    reload   = CNT_W'(n);
    cmp_x    = CNT_W'(cx);
    cmp_y    = CNT_W'(cy);
    pulse_restart();
    for (int k = 0; k < kmax; k++) begin
      int m, mm, c, dn;
      bit tk, live, to;
      string tag;
      @(negedge clk);
      m    = k / (p + 1);
      tk   = (k % (p + 1)) == p;
      live = (per == 1) || (m <= n);
      dn   = 0;
      c    = 0;
      to   = 1'b0;
      if (dirc == 2) begin
        c  = (per == 1) ? m % (n + 1) : ((m < n) ? m : n);
        to = tk && live && ((per == 1) ? (c == n) : (m == n));
      end else if (dirc == 1) begin
        c  = (per == 1) ? n - (m % (n + 1)) : ((m < n) ? n - m : 0);
        to = tk && live && ((per == 1) ? (c == 0) : (m == n));
        dn = 1;
      end else begin
        if (per == 1) begin
          mm = m % (2 * n);
          c  = (mm <= n) ? mm : 2 * n - mm;
          to = tk && (mm == n);
          dn = ((mm > n) || (mm == 0 && m > 0)) ? 1 : 0;
        end else begin
          c  = (m < n) ? m : n;
          to = tk && (m == n);
        end
      end
      tag = (dirc == 2) ? "R2" : (dirc == 1) ? "R3" : "R4";
      if (per == 0) tag = {tag, " R7"};
      if (p > 0)    tag = {tag, " R1"};
      if (k == 0)   tag = {tag, " R8"};
      check(tag, "count", longint'(count), longint'(c));
      check({tag, " R5"}, "timeout", longint'(timeout), longint'(to));
      check({tag, " R6"}, "match_x", longint'(match_x), longint'(tk && live && c == cx));
      check({tag, " R6"}, "match_y", longint'(match_y), longint'(tk && live && c == cy));
      check({tag, " R4"}, "counting_down", longint'(counting_down), longint'(dn));
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "count", longint'(count), 0);
    check("R11", "timeout", longint'(timeout), 0);
    check("R11", "match_x", longint'(match_x), 0);
    check("R11", "match_y", longint'(match_y), 0);
    check("R11", "counting_down", longint'(counting_down), 0);
    enable = 1'b1;

    for (int d = 1; d <= 3; d++)
      for (int per = 0; per <= 1; per++)
        for (int p = 0; p <= 2; p++)
          for (int n = (d == 3 ? 1 : 0); n <= 4; n++)
            run_case(d, per, p, n, 40);

    // R10: hold direction with a compare sitting on the count
    @(negedge clk);
    mode_cfg = 3'b110; prescale = '0; reload = CNT_W'(20); cmp_x = CNT_W'(30); cmp_y = CNT_W'(30);
    pulse_restart();
    repeat (4) @(negedge clk);
    check("R10", "count before hold", longint'(count), 3);
    mode_cfg = 3'b100;
    cmp_x = CNT_W'(3);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10", "held count", longint'(count), 3);
      check("R10", "match_x while held", longint'(match_x), 0);
      check("R10", "timeout while held", longint'(timeout), 0);
    end

    // R9: disable freezes, re-enable waits a full prescale period
    @(negedge clk);
    mode_cfg = 3'b110; prescale = PRE_W'(1); reload = CNT_W'(10); cmp_x = CNT_W'(30); cmp_y = CNT_W'(30);
    pulse_restart();
    repeat (6) @(negedge clk);
    check("R9", "count before disable", longint'(count), 2);
    enable = 1'b0;
    cmp_x = CNT_W'(2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9", "frozen count", longint'(count), 2);
      check("R9", "match_x while disabled", longint'(match_x), 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check("R9 R1", "count one edge after enable", longint'(count), 2);
    check("R9 R6", "match_x on first tick", longint'(match_x), 1);
    @(negedge clk);
    check("R9 R1", "count two edges after enable", longint'(count), 3);
    check("R9 R6", "match_x after step", longint'(match_x), 0);

    finish_run();
  end

endmodule